// File: doc/BRIEF.md
# Two-Way Single-Channel Mailbox

This block lets two processors, called side A and side B, hand each other short messages. Each message is a 32-bit command word plus a 32-bit data word. There is one channel for each direction. A sender writes its command and data registers, which sets a pending flag. The pending flag drives an interrupt toward the receiver when that interrupt is enabled. The receiver reads the words and then writes 1 to the status register to release the channel. Side A owns the configuration: it writes both interrupt-enable registers. It also chooses how the A-to-B direction posts: on the command write alone, or only after a command write followed by a data write.

Each side has its own register port, built as a valid/ready request channel with a read-response strobe. The request channel never applies back-pressure: `x_ready` is always high, and every request with `x_valid` high completes on the edge it is presented. A read returns its data with `x_rvalid` high one cycle later. The response has no ready and must be taken when it arrives. Address bits [1:0] are ignored. Register words sit at byte offsets 0x00 to 0x1C, and every higher offset is undefined.

Register words: 0x00 A-to-B enable (bit 0 is the interrupt enable, bit 8 is the trigger mode); 0x04 A-to-B status; 0x08 A-to-B command; 0x0C A-to-B data; 0x10 B-to-A enable (bit 0); 0x14 B-to-A status; 0x18 B-to-A command; 0x1C B-to-A data.

Top module: `mbox_duplex`

## Requirements
- R1: After reset, every register reads 0, both interrupt outputs are low, and both `x_rvalid` outputs are low.
- R2: `x_ready` is always 1. A read request completes on its edge, and `x_rdata` holds the addressed word with `x_rvalid` high in the next cycle. Both sides can read every register, and address bits [1:0] are ignored.
- R3: An A write to an enable register updates bit n only when bit n+16 of the written word is 1. Only bits 0 and 8 (A-to-B) or bit 0 (B-to-A) exist, and all other bits read 0.
- R4: With A-to-B enable bit 8 equal to 0, an A write to 0x08 stores the command and sets A-to-B status bit 0.
- R5: With A-to-B enable bit 8 equal to 1, status is set only by an A write to 0x0C that follows an A write to 0x08 since the last post. A data write with no such command write leaves status at 0. Posting clears the armed state.
- R6: A B write to 0x18 stores the B-to-A command and sets B-to-A status bit 0. A B write to 0x1C stores the data word.
- R7: `irq_to_b` equals A-to-B status bit 0 AND A-to-B enable bit 0. `irq_to_a` equals B-to-A status bit 0 AND B-to-A enable bit 0.
- R8: A write with bit 0 = 1 to 0x04 from B, or to 0x14 from A, clears that status bit. Writing 0 has no effect, and a status write from the sending side has no effect.
- R9: Command and data writes from the receiving side, and enable writes from side B, leave the registers unchanged.
- R10: Reads of offsets 0x20 and above return 0, and writes there change nothing.
- R11: When a post and a clear of the same status bit land on the same edge, the status ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_valid | input | 1 | Side A request valid |
| a_ready | output | 1 | Side A request accepted (always 1) |
| a_write | input | 1 | Side A: 1 = write, 0 = read |
| a_addr | input | ADDR_W | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rvalid | output | 1 | Side A read data valid |
| a_rdata | output | 32 | Side A read data |
| b_valid | input | 1 | Side B request valid |
| b_ready | output | 1 | Side B request accepted (always 1) |
| b_write | input | 1 | Side B: 1 = write, 0 = read |
| b_addr | input | ADDR_W | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rvalid | output | 1 | Side B read data valid |
| b_rdata | output | 32 | Side B read data |
| irq_to_a | output | 1 | B-to-A message pending and enabled |
| irq_to_b | output | 1 | A-to-B message pending and enabled |

## Verification
The hardest case to reach is a post and a clear of the same status bit on one edge. No single port can produce it. The bench drives both ports in the same cycle: side A writes the command while side B writes 1 to the A-to-B status. The armed state of the two-step trigger cannot be seen at the ports. The bench therefore exposes it through sequences: a data write alone, a command with no data, and a second data write after a post. Status is read back after each step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_WORDS = 8;
  localparam int unsigned IDX_W     = 3;

  typedef enum logic [IDX_W-1:0] {
    RG_A2B_EN  = 3'd0,
    RG_A2B_ST  = 3'd1,
    RG_A2B_CMD = 3'd2,
    RG_A2B_DAT = 3'd3,
    RG_B2A_EN  = 3'd4,
    RG_B2A_ST  = 3'd5,
    RG_B2A_CMD = 3'd6,
    RG_B2A_DAT = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic [NUM_WORDS-1:0] wr_hit,
  output logic                 rd_fire,
  output logic                 rd_defined,
  output logic [IDX_W-1:0]     rd_idx
);
  logic [ADDR_W-1:0] word_addr;
  logic              in_range;

  assign word_addr  = req_addr >> 2;
  assign in_range   = (word_addr < ADDR_W'(NUM_WORDS));
  assign rd_idx     = word_addr[IDX_W-1:0];
  assign rd_fire    = req_valid && !req_write;
  assign rd_defined = in_range;
  assign wr_hit     = (req_valid && req_write && in_range)
                      ? (NUM_WORDS'(1) << word_addr[IDX_W-1:0]) : '0;
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DATA_W      = 32,
  parameter bit          HAS_TRIGGER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic [DATA_W-1:0] en_wdata,
  input  logic              cmd_we,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_we,
  input  logic              clr_bit,
  output logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] dat_q,
  output logic              irq
);
  localparam int unsigned       HALF     = DATA_W / 2;
  localparam int unsigned       TRIG_BIT = 8;
  localparam logic [HALF-1:0]   ONE      = {{(HALF-1){1'b0}}, 1'b1};
  localparam logic [HALF-1:0]   EN_BITS  = ONE | (HAS_TRIGGER ? (ONE << TRIG_BIT) : '0);

  logic [HALF-1:0] en_r;
  logic [HALF-1:0] en_mask;
  logic            pend;
  logic            post;

  assign en_mask = en_wdata[DATA_W-1:HALF] & EN_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r  <= '0;
      cmd_q <= '0;
      dat_q <= '0;
    end else begin
      if (en_we)  en_r  <= (en_r & ~en_mask) | (en_wdata[HALF-1:0] & en_mask);
      if (cmd_we) cmd_q <= wdata;
      if (dat_we) dat_q <= wdata;
    end
  end

  generate
    if (HAS_TRIGGER) begin : g_trig
      logic armed;
      logic two_step;
      assign two_step = en_r[TRIG_BIT];
      assign post     = two_step ? (dat_we && armed) : cmd_we;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  armed <= 1'b0;
        else if (post)               armed <= 1'b0;
        else if (cmd_we && two_step) armed <= 1'b1;
      end
    end else begin : g_cmd_only
      assign post = cmd_we;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (post)               pend <= 1'b1;
    else if (clr_we && clr_bit)  pend <= 1'b0;
  end

  assign irq      = pend && en_r[0];
  assign en_q     = {{(DATA_W-HALF){1'b0}}, en_r};
  assign status_q = {{(DATA_W-1){1'b0}}, pend};
endmodule

// File: rtl/mbox_duplex.sv
module mbox_duplex
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic              a_write,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic              a_rvalid,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic              b_write,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic              b_rvalid,
  output logic [DATA_W-1:0] b_rdata,
  output logic              irq_to_a,
  output logic              irq_to_b
);
  localparam int unsigned SIDES = 2;

  logic [SIDES-1:0]                 s_valid, s_write;
  logic [SIDES-1:0][ADDR_W-1:0]     s_addr;
  logic [SIDES-1:0][NUM_WORDS-1:0]  s_hit;
  logic [SIDES-1:0]                 s_rd, s_def;
  logic [SIDES-1:0][IDX_W-1:0]      s_idx;
  logic [SIDES-1:0]                 s_rvalid;
  logic [SIDES-1:0][DATA_W-1:0]     s_rdata;
  logic [DATA_W-1:0]                regs [NUM_WORDS];
  logic                             unused_hits;

  assign s_valid = {b_valid, a_valid};
  assign s_write = {b_write, a_write};
  assign s_addr  = {b_addr, a_addr};

  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      mbx_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (s_valid[s]),
        .req_write (s_write[s]),
        .req_addr  (s_addr[s]),
        .wr_hit    (s_hit[s]),
        .rd_fire   (s_rd[s]),
        .rd_defined(s_def[s]),
        .rd_idx    (s_idx[s])
      );
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_rvalid[s] <= 1'b0;
          s_rdata[s]  <= '0;
        end else begin
          s_rvalid[s] <= s_rd[s];
          if (s_rd[s]) s_rdata[s] <= s_def[s] ? regs[s_idx[s]] : '0;
        end
      end
    end
  endgenerate

  mbx_channel #(.DATA_W(DATA_W), .HAS_TRIGGER(1'b1)) u_a2b (
    .clk(clk), .rst_n(rst_n),
    .en_we   (s_hit[0][RG_A2B_EN]),  .en_wdata(a_wdata),
    .cmd_we  (s_hit[0][RG_A2B_CMD]), .dat_we  (s_hit[0][RG_A2B_DAT]),
    .wdata   (a_wdata),
    .clr_we  (s_hit[1][RG_A2B_ST]),  .clr_bit (b_wdata[0]),
    .en_q    (regs[RG_A2B_EN]),  .status_q(regs[RG_A2B_ST]),
    .cmd_q   (regs[RG_A2B_CMD]), .dat_q   (regs[RG_A2B_DAT]),
    .irq     (irq_to_b)
  );

  mbx_channel #(.DATA_W(DATA_W), .HAS_TRIGGER(1'b0)) u_b2a (
    .clk(clk), .rst_n(rst_n),
    .en_we   (s_hit[0][RG_B2A_EN]),  .en_wdata(a_wdata),
    .cmd_we  (s_hit[1][RG_B2A_CMD]), .dat_we  (s_hit[1][RG_B2A_DAT]),
    .wdata   (b_wdata),
    .clr_we  (s_hit[0][RG_B2A_ST]),  .clr_bit (a_wdata[0]),
    .en_q    (regs[RG_B2A_EN]),  .status_q(regs[RG_B2A_ST]),
    .cmd_q   (regs[RG_B2A_CMD]), .dat_q   (regs[RG_B2A_DAT]),
    .irq     (irq_to_a)
  );

  assign unused_hits = ^{s_hit[0][RG_A2B_ST], s_hit[0][RG_B2A_CMD], s_hit[0][RG_B2A_DAT],
                         s_hit[1][RG_A2B_EN], s_hit[1][RG_A2B_CMD], s_hit[1][RG_A2B_DAT],
                         s_hit[1][RG_B2A_EN], s_hit[1][RG_B2A_ST]};

  assign a_ready  = 1'b1;
  assign b_ready  = 1'b1;
  assign a_rvalid = s_rvalid[0];
  assign b_rvalid = s_rvalid[1];
  assign a_rdata  = s_rdata[0];
  assign b_rdata  = s_rdata[1];
endmodule

// File: rtl/mbox_duplex_chk.sv
module mbox_duplex_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_valid,
  input logic              a_write,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_rvalid,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_valid,
  input logic              b_write,
  input logic              b_rvalid,
  input logic              irq_to_a,
  input logic              irq_to_b
);
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_write) |=> a_rvalid);

  p_no_spurious_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_valid && !b_write) |=> !b_rvalid);

  p_undef_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_write && ((a_addr >> 5) != '0)) |=> (a_rdata == '0));

  p_irq_b_rise_from_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_to_b) |-> $past(a_valid && a_write));

  p_irq_b_fall_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_to_b) |-> $past((b_valid && b_write) || (a_valid && a_write)));

  p_irq_a_rise_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_to_a) |-> $past((b_valid && b_write) || (a_valid && a_write)));
endmodule

bind mbox_duplex mbox_duplex_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_write(a_write), .a_addr(a_addr),
  .a_rvalid(a_rvalid), .a_rdata(a_rdata),
  .b_valid(b_valid), .b_write(b_write), .b_rvalid(b_rvalid),
  .irq_to_a(irq_to_a), .irq_to_b(irq_to_b)
);

// File: tb/mbox_duplex_test.sv
module mbox_duplex_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 0, a_write = 0, b_valid = 0, b_write = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic a_ready, b_ready, a_rvalid, b_rvalid, irq_to_a, irq_to_b;
  logic [31:0] a_rdata, b_rdata;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_duplex #(.ADDR_W(AW), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_write(a_write), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_valid(b_valid), .b_ready(b_ready), .b_write(b_write), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rvalid(b_rvalid), .b_rdata(b_rdata),
    .irq_to_a(irq_to_a), .irq_to_b(irq_to_b)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input bit side_b, input logic [AW-1:0] addr, input logic [31:0] data);
    @(negedge clk);
    if (side_b) begin b_valid = 1; b_write = 1; b_addr = addr; b_wdata = data; end
    else        begin a_valid = 1; a_write = 1; a_addr = addr; a_wdata = data; end
    @(negedge clk);
    a_valid = 0; a_write = 0; b_valid = 0; b_write = 0;
  endtask

  task automatic rd(input bit side_b, input logic [AW-1:0] addr, output logic [31:0] data);
    @(negedge clk);
    if (side_b) begin b_valid = 1; b_write = 0; b_addr = addr; end
    else        begin a_valid = 1; a_write = 0; a_addr = addr; end
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    chk("R2", "rvalid one cycle after read", side_b ? b_rvalid : a_rvalid, 1);
    data = side_b ? b_rdata : a_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "irq_to_a after reset", irq_to_a, 0);
    chk("R1", "irq_to_b after reset", irq_to_b, 0);
    chk("R1", "a_rvalid after reset", a_rvalid, 0);
    chk("R2", "ready high", {a_ready, b_ready}, 2'b11);
    for (int i = 0; i < 8; i++) begin
      rd(0, AW'(i*4), v);
      chk("R1", "register zero after reset", v, 0);
    end
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(0, 6'h00, 32'h0000_0001); rd(0, 6'h00, v); chk("R3", "unmasked write ignored", v, 0);
    wr(0, 6'h00, 32'h0001_0001); rd(0, 6'h00, v); chk("R3", "bit0 set via mask", v, 32'h1);
    wr(0, 6'h00, 32'h0100_0100); rd(0, 6'h00, v); chk("R3", "bit8 set, bit0 kept", v, 32'h101);
    wr(0, 6'h00, 32'h0001_0000); rd(0, 6'h00, v); chk("R3", "bit0 cleared only", v, 32'h100);
    wr(0, 6'h00, 32'hFFFF_FFFF); rd(0, 6'h00, v); chk("R3", "only bits 0 and 8 exist", v, 32'h101);
    wr(1, 6'h00, 32'h0101_0000); rd(1, 6'h00, v); chk("R9", "B enable write ignored", v, 32'h101);
    wr(0, 6'h00, 32'h0100_0000); rd(0, 6'h00, v); chk("R3", "trigger back to cmd mode", v, 32'h1);
  endtask

  task automatic t_cmd_post();
    logic [31:0] v;
    wr(0, 6'h0C, 32'h1111_2222);
    chk("R4", "data write alone in cmd mode does not post", irq_to_b, 0);
    wr(0, 6'h08, 32'hC0DE_0001);
    chk("R4", "irq_to_b after command write", irq_to_b, 1);
    rd(1, 6'h04, v); chk("R4", "A2B status from B", v, 1);
    rd(1, 6'h08, v); chk("R2", "B reads A2B command", v, 32'hC0DE_0001);
    rd(1, 6'h0E, v); chk("R2", "low address bits ignored", v, 32'h1111_2222);
    wr(1, 6'h08, 32'hDEAD_BEEF);
    rd(0, 6'h08, v); chk("R9", "B write to A2B command ignored", v, 32'hC0DE_0001);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(0, 6'h04, 32'h1); chk("R8", "sender clear ignored", irq_to_b, 1);
    wr(1, 6'h04, 32'h0); chk("R8", "writing 0 keeps status", irq_to_b, 1);
    wr(1, 6'h04, 32'h1); chk("R8", "receiver clear drops irq", irq_to_b, 0);
    rd(0, 6'h04, v); chk("R8", "status cleared", v, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(0, 6'h00, 32'h0001_0000);
    wr(0, 6'h08, 32'h0000_00AA);
    chk("R7", "disabled irq stays low", irq_to_b, 0);
    rd(1, 6'h04, v); chk("R7", "status set while disabled", v, 1);
    wr(0, 6'h00, 32'h0001_0001);
    chk("R7", "enable exposes pending", irq_to_b, 1);
    wr(1, 6'h04, 32'h1);
    chk("R8", "cleared after gate test", irq_to_b, 0);
  endtask

  task automatic t_two_step();
    logic [31:0] v;
    wr(0, 6'h00, 32'h0100_0100);
    wr(0, 6'h0C, 32'h0000_0D01);
    rd(0, 6'h04, v); chk("R5", "data without command no post", v, 0);
    wr(0, 6'h08, 32'h0000_0C01);
    rd(0, 6'h04, v); chk("R5", "command alone no post", v, 0);
    chk("R5", "irq low after command alone", irq_to_b, 0);
    wr(0, 6'h0C, 32'h0000_0D02);
    chk("R5", "command then data posts", irq_to_b, 1);
    rd(1, 6'h0C, v); chk("R5", "data word stored", v, 32'h0000_0D02);
    wr(1, 6'h04, 32'h1);
    wr(0, 6'h0C, 32'h0000_0D03);
    rd(0, 6'h04, v); chk("R5", "armed state cleared by post", v, 0);
    wr(0, 6'h00, 32'h0100_0000);
  endtask

  task automatic t_b2a();
    logic [31:0] v;
    wr(0, 6'h10, 32'h0001_0001);
    wr(1, 6'h1C, 32'h5555_AAAA);
    chk("R6", "data write alone no B2A post", irq_to_a, 0);
    wr(1, 6'h18, 32'h0000_0B0B);
    chk("R6", "irq_to_a after B command", irq_to_a, 1);
    rd(0, 6'h18, v); chk("R6", "A reads B2A command", v, 32'h0000_0B0B);
    rd(0, 6'h1C, v); chk("R6", "A reads B2A data", v, 32'h5555_AAAA);
    wr(0, 6'h18, 32'h1234_5678);
    rd(1, 6'h18, v); chk("R9", "A write to B2A command ignored", v, 32'h0000_0B0B);
    wr(1, 6'h14, 32'h1); chk("R8", "B cannot clear B2A status", irq_to_a, 1);
    wr(0, 6'h14, 32'h1); chk("R8", "A clears B2A status", irq_to_a, 0);
  endtask

  task automatic t_undef();
    logic [31:0] v;
    wr(0, 6'h20, 32'hFFFF_FFFF);
    rd(0, 6'h20, v); chk("R10", "undefined offset reads zero", v, 0);
    rd(1, 6'h3C, v); chk("R10", "top offset reads zero", v, 0);
    rd(0, 6'h00, v); chk("R10", "undefined write changed nothing", v, 32'h1);
  endtask

  task automatic t_collide();
    wr(0, 6'h08, 32'h0000_0001);
    @(negedge clk);
    a_valid = 1; a_write = 1; a_addr = 6'h08; a_wdata = 32'h0000_0002;
    b_valid = 1; b_write = 1; b_addr = 6'h04; b_wdata = 32'h1;
    @(negedge clk);
    a_valid = 0; a_write = 0; b_valid = 0; b_write = 0;
    chk("R11", "post wins over same-cycle clear", irq_to_b, 1);
    wr(1, 6'h04, 32'h1);
    chk("R11", "later clear works", irq_to_b, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_cmd_post();
    t_clear();
    t_gate();
    t_two_step();
    t_b2a();
    t_undef();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule